// File: doc/BRIEF.md
# Write Strobe Qualifier and Inhibit

This block sits between the asynchronous control pins of a parallel memory and the write sequencer behind them. It samples the active-low chip-enable, write-enable and output-enable pins and a digital supply-good bit on a fast sampling clock. It turns the active-low AND of chip-enable and write-enable into two clean single-cycle events. `wr_start` marks the moment the write strobe opens, which is when the later of the two enables falls and the sequencer should capture the address. `wr_end` marks the moment it closes, which is when the first of the two enables rises and the sequencer should capture the data.

A strobe produces these events only when three conditions hold. Each enable pin must have held its new level for a minimum number of sample clocks, so narrow glitches are discarded. The supply-good bit must have stayed high for a full power-on lockout period. The output-enable pin must be high. If the supply drops, or output-enable falls, while a strobe is open, the strobe is dropped silently. A supply drop also restarts the lockout period from zero.

Top module: `wr_strobe_qual`

## Requirements
- R1: After reset, `wr_start` and `wr_end` are low, and they stay low until a qualified strobe occurs.
- R2: `wr_start` never fires while the lockout is running. The lockout runs while the synchronized supply-good bit is low and for `LOCK_CYC` sample clocks after it goes high. A strobe that opens during the lockout gives no events, even if it stays open past the end of the lockout.
- R3: A strobe that opens while `oe_n` is low gives no events. If `oe_n` goes low while a strobe is open, the strobe is dropped and no `wr_end` follows.
- R4: A low pulse on `ce_n` or `we_n` that lasts fewer than `MIN_W` sample clocks is ignored. A low level held for `MIN_W` or more clocks counts. The same rule applies to high pulses.
- R5: `wr_start` is asserted exactly `MIN_W + 3` clock edges after the clock edge that first samples the later of the two falling enables. The count is 2 synchronizer stages, then `MIN_W` filter clocks, then 1 output register.
- R6: `wr_end` is asserted exactly `MIN_W + 3` clock edges after the clock edge that first samples the first of the two rising enables.
- R7: Both outputs are single-cycle pulses, and they are never high together. Each qualified strobe gives exactly one `wr_start` followed by exactly one `wr_end`.
- R8: If supply-good falls while a strobe is open, the strobe is dropped and no `wr_end` follows. The lockout then restarts from zero when supply-good returns.
- R9: The block treats both enable orders the same way: chip-enable falling first, or write-enable falling first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good bit from the analog sensor; high means the supply is adequate |
| ce_n | input | 1 | Chip-enable pin, active low, asynchronous |
| we_n | input | 1 | Write-enable pin, active low, asynchronous |
| oe_n | input | 1 | Output-enable pin, active low, asynchronous |
| wr_start | output | 1 | One-cycle pulse when a qualified strobe opens (address capture) |
| wr_end | output | 1 | One-cycle pulse when a qualified strobe closes (data capture) |

## Verification
The assertions check the following properties on every cycle:
- The filter only adopts a level that was already present on its synchronized input.
- The lockout is cleared in the cycle after supply-good is seen low.
- A `wr_start` pulse is always preceded by an expired lockout and a high output-enable.
- Both events are single-cycle pulses and never coincide.

Other behaviours need whole scenarios, and only the bench can show them. These include the pulse-width acceptance rule for either enable order, the exact `MIN_W + 3` latency, and a strobe that stays open past the end of the lockout. They also include the silent drop with no `wr_end`, when supply-good or output-enable falls in the middle of a strobe.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

  // True when a run counter holding cnt has seen its lim-th consecutive sample.
  function automatic logic run_complete(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

  // Pin-to-event latency in sample clock edges: 2 sync + filter + output reg.
  function automatic int unsigned event_latency(input int unsigned min_w);
    return min_w + 3;
  endfunction

endpackage

// File: rtl/wsq_sync2.sv
module wsq_sync2 #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_o <= RST_VAL;
    end else begin
      meta_q <= async_i;
      sync_o <= meta_q;
    end
  end
endmodule

// File: rtl/wsq_glitch_filt.sv
module wsq_glitch_filt
  import wsq_pkg::*;
#(
  parameter int unsigned MIN_W = 4,
  parameter logic        RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic filt_o
);
  localparam int unsigned CW = (MIN_W > 1) ? $clog2(MIN_W) : 1;

  logic [CW-1:0] run_q;
  logic          differs;
  logic          accept;

  assign differs = (pin_i != filt_o);
  assign accept  = differs && run_complete(32'(run_q), MIN_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      filt_o <= RST_LVL;
    end else if (accept) begin
      run_q  <= '0;
      filt_o <= pin_i;
    end else if (differs) begin
      run_q  <= run_q + 1'b1;
    end else begin
      run_q  <= '0;
    end
  end

  // R4: the filtered level only ever moves to a level present on its input
  p_filt_follows_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_o) |-> (filt_o == $past(pin_i)));

endmodule

// File: rtl/wsq_lockout.sv
module wsq_lockout
  import wsq_pkg::*;
#(
  parameter int unsigned LOCK_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_i,
  output logic armed_o
);
  localparam int unsigned CW = $clog2(LOCK_CYC + 1);

  logic [CW-1:0] tick_q;
  logic          expire;

  assign expire = run_complete(32'(tick_q), LOCK_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      armed_o <= 1'b0;
    end else if (!sup_i) begin
      tick_q  <= '0;
      armed_o <= 1'b0;
    end else if (!armed_o) begin
      if (expire) armed_o <= 1'b1;
      else        tick_q  <= tick_q + 1'b1;
    end
  end

  // R8: a low supply sample restarts the lockout from zero
  p_lock_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_i |=> (!armed_o && tick_q == '0));

endmodule

// File: rtl/wsq_strobe_fsm.sv
module wsq_strobe_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_f,
  input  logic we_f,
  input  logic oe_s,
  input  logic armed,
  output logic wr_start,
  output logic wr_end
);
  logic strobe_on;
  logic strobe_q;
  logic open_q;
  logic allowed;
  logic open_evt;
  logic close_evt;
  logic drop_evt;

  assign strobe_on = ~ce_f & ~we_f;
  assign allowed   = armed & oe_s;
  assign open_evt  = strobe_on & ~strobe_q & allowed & ~open_q;
  assign drop_evt  = open_q & ~allowed;
  assign close_evt = open_q & allowed & ~strobe_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      open_q   <= 1'b0;
      wr_start <= 1'b0;
      wr_end   <= 1'b0;
    end else begin
      strobe_q <= strobe_on;
      wr_start <= open_evt;
      wr_end   <= close_evt;
      if (open_evt)                   open_q <= 1'b1;
      else if (drop_evt || close_evt) open_q <= 1'b0;
    end
  end

  // R7: single-cycle pulses that never coincide
  p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);
  p_end_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> !wr_end);
  p_no_coincide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_start && wr_end));

endmodule

// File: rtl/wr_strobe_qual.sv
module wr_strobe_qual #(
  parameter int unsigned MIN_W    = 4,
  parameter int unsigned LOCK_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_start,
  output logic wr_end
);
  localparam int unsigned NPIN  = 4;
  localparam int unsigned NFILT = 2;
  localparam int unsigned I_CE  = 0;
  localparam int unsigned I_WE  = 1;
  localparam int unsigned I_OE  = 2;
  localparam int unsigned I_SUP = 3;
  localparam logic [NPIN-1:0] PIN_IDLE = 4'b0111;

  logic [NPIN-1:0]  pin_raw;
  logic [NPIN-1:0]  pin_s;
  logic [NFILT-1:0] en_f;
  logic             armed;
  logic             oe_s;

  assign pin_raw = {supply_ok, oe_n, we_n, ce_n};
  assign oe_s    = pin_s[I_OE];

  wsq_sync2 #(.W(NPIN), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_raw), .sync_o(pin_s));

  for (genvar g = 0; g < NFILT; g++) begin : g_filt
    wsq_glitch_filt #(.MIN_W(MIN_W), .RST_LVL(1'b1)) u_filt (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_s[g]), .filt_o(en_f[g]));
  end

  wsq_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .sup_i(pin_s[I_SUP]), .armed_o(armed));

  wsq_strobe_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ce_f(en_f[I_CE]), .we_f(en_f[I_WE]),
    .oe_s(oe_s), .armed(armed), .wr_start(wr_start), .wr_end(wr_end));

  // R2: an opening strobe event requires an expired lockout
  p_start_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> $past(armed));
  // R3: an opening strobe event requires output-enable high
  p_start_oe_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> $past(oe_s));

endmodule

// File: tb/wr_strobe_qual_tb.sv
module wr_strobe_qual_tb;
  localparam int unsigned MW   = 3;
  localparam int unsigned LOCK = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic wr_start, wr_end;

  int unsigned cyc = 0;
  int unsigned n_start = 0, n_end = 0, last_start = 0, last_end = 0;
  int unsigned tests = 0, fails = 0;

  always #10 clk = ~clk;

  wr_strobe_qual #(.MIN_W(MW), .LOCK_CYC(LOCK)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n),
    .we_n(we_n), .oe_n(oe_n), .wr_start(wr_start), .wr_end(wr_end));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && wr_start) begin n_start++; last_start = cyc; end
    if (rst_n && wr_end)   begin n_end++;   last_end   = cyc; end
  end

  // Bench's own model of the rules.
  function automatic bit width_ok(int unsigned w);
    return w >= MW;
  endfunction
  function automatic int unsigned lat();
    return MW + 3;
  endfunction

  task automatic chk(string req, int unsigned act, int unsigned exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int unsigned n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_en(bit sel_ce, logic v);
    if (sel_ce) ce_n = v; else we_n = v;
  endtask

  // One strobe: lead pin falls, d1 later the other falls; n later the first
  // riser goes high, g later the other. armed_exp: lockout expired.
  task automatic strobe(string req, bit lead_ce, int unsigned d1, int unsigned n,
                        int unsigned g, bit lead_rises_first, bit oe_hi, bit armed_exp);
    int unsigned s0, e0, c_fall2, c_rise1, w_lead, w_sec;
    bit exp;
    @(negedge clk); oe_n = oe_hi;
    idle(6);
    s0 = n_start; e0 = n_end;
    @(negedge clk); drive_en(lead_ce, 1'b0);
    if (d1 > 0) idle(d1);
    drive_en(!lead_ce, 1'b0); c_fall2 = cyc;
    idle(n);
    drive_en(lead_rises_first ? lead_ce : !lead_ce, 1'b1); c_rise1 = cyc;
    idle(g);
    drive_en(lead_rises_first ? !lead_ce : lead_ce, 1'b1);
    idle(MW + 10);
    w_lead = d1 + n + (lead_rises_first ? 0 : g);
    w_sec  = n + (lead_rises_first ? g : 0);
    exp = armed_exp && oe_hi && width_ok(w_lead) && width_ok(w_sec);
    chk({req, " start count"}, n_start - s0, exp);
    chk({req, " end count"}, n_end - e0, exp);
    if (exp) begin
      chk("R5 start latency", last_start - c_fall2, lat());
      chk("R6 end latency", last_end - c_rise1, lat());
    end
  endtask

  initial begin
    int unsigned s0, e0;
    void'($urandom(32'd1234));
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R1 start low after reset", wr_start, 0);
    chk("R1 end low after reset", wr_end, 0);

    // R2: supply low blocks everything
    strobe("R2 supply low", 1'b1, 1, 6, 2, 1'b0, 1'b1, 1'b0);

    // R2: strobe opened during lockout and held past its end
    @(negedge clk); supply_ok = 1'b1;
    s0 = n_start; e0 = n_end;
    idle(2); ce_n = 1'b0; idle(1); we_n = 1'b0;
    idle(LOCK + 20);
    we_n = 1'b1; ce_n = 1'b1;
    idle(MW + 10);
    chk("R2 held through lockout start", n_start - s0, 0);
    chk("R2 held through lockout end", n_end - e0, 0);

    // Now armed: both orders and glitch corners (R4, R9)
    strobe("R9 ce first", 1'b1, 2, 6, 2, 1'b0, 1'b1, 1'b1);
    strobe("R9 we first", 1'b0, 2, 6, 2, 1'b1, 1'b1, 1'b1);
    strobe("R4 we glitch short", 1'b1, 2, MW - 1, 5, 1'b0, 1'b1, 1'b1);
    strobe("R4 we width exact", 1'b1, 2, MW, 5, 1'b0, 1'b1, 1'b1);
    strobe("R4 ce glitch short", 1'b0, 2, MW - 1, 5, 1'b0, 1'b1, 1'b1);
    strobe("R3 oe low", 1'b1, 1, 6, 2, 1'b0, 1'b0, 1'b1);

    // Random mix (R4, R5, R6, R9, R3)
    for (int i = 0; i < 80; i++) begin
      strobe("R4 random", 1'($urandom_range(0, 1)), $urandom_range(0, 3),
             $urandom_range(1, 6), $urandom_range(1, 3), 1'($urandom_range(0, 1)),
             ($urandom_range(0, 4) != 0), 1'b1);
    end

    // R3: oe falls mid-strobe, no end
    @(negedge clk); oe_n = 1'b1; idle(6);
    s0 = n_start; e0 = n_end;
    we_n = 1'b0; ce_n = 1'b0; idle(MW + 8);
    chk("R3 mid-strobe opened", n_start - s0, 1);
    oe_n = 1'b0; idle(6);
    ce_n = 1'b1; we_n = 1'b1; idle(MW + 8);
    oe_n = 1'b1; idle(6);
    chk("R3 mid-strobe no end", n_end - e0, 0);
    chk("R7 no stray start", n_start - s0, 1);

    // R8: supply drops mid-strobe, no end, lockout restarts
    s0 = n_start; e0 = n_end;
    ce_n = 1'b0; we_n = 1'b0; idle(MW + 8);
    chk("R8 mid-strobe opened", n_start - s0, 1);
    supply_ok = 1'b0; idle(6);
    ce_n = 1'b1; we_n = 1'b1; idle(MW + 8);
    chk("R8 no end after drop", n_end - e0, 0);
    @(negedge clk); supply_ok = 1'b1;
    strobe("R8 relock", 1'b1, 1, 4, 1, 1'b1, 1'b1, 1'b0);
    idle(LOCK + 5);
    strobe("R8 rearmed", 1'b0, 1, 5, 1, 1'b0, 1'b1, 1'b1);

    chk("R7 start/end balance", n_start - n_end, 2);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule